// File: doc/BRIEF.md
# Bus-Master DMA Register Block

This block is the software-visible register file of a two-channel bus-master DMA engine for a disk controller. It sits on a byte-addressed I/O window of 16 bytes, 8 bytes per channel. Each channel slice has three parts. A control byte starts or stops the channel and selects the transfer direction. A status byte holds the transfer-active flag, error and interrupt flags that software clears by writing ones, and two general-purpose bits. A 32-bit descriptor-table pointer tells the engine where its list of transfers starts.

The host reaches the block through a simple I/O port: an address, a byte-count size indicator, write data, and read and write strobes. Read data is combinational in the cycle of the read strobe, and reads change no state. On the hardware side, each channel has three inputs: an error pulse, an interrupt pulse, and a pulse that ends the active transfer. The block drives the run bit, the direction bit, the active flag and the aligned pointer of each channel to the engine.

Top module: `bmdma_regblock`

## Requirements
- R1: After reset, every control byte, status byte and pointer byte of both channels reads 0x00, and the run, direction and active outputs are 0.
- R2: A write whose size indicator is not 1 changes no register.
- R3: A read whose size indicator is not 1 returns ones in the low size*8 bits of `io_rdata` and zeros above them: size 2 gives 0x0000FFFF and size 4 gives 0xFFFFFFFF.
- R4: Inside a channel's control/status sub-window, byte offsets 1 and 3 read 0xFF. So window offsets 1, 3, 9 and 11 read 0xFF.
- R5: A status write loads bits 6:5 from the written byte. Status bits 7, 4 and 3 always read 0.
- R6: Status bits 2 (interrupt) and 1 (error) are cleared by writing a 1 to that bit position. Writing a 0 keeps the bit.
- R7: Status bit 0 (active) is never changed by a status write.
- R8: A control write (offset 0) with bit 0 set sets the run output and status bit 0. A control write with bit 0 clear clears both. Control bit 3 drives the direction output. The control byte reads back only bits 3 and 0.
- R9: An engine-done pulse clears status bit 0 and leaves the run bit unchanged. If a control write arrives in the same cycle, the control write wins.
- R10: An error pulse sets status bit 1 and an interrupt pulse sets status bit 2. When a pulse and a clearing status write hit the same cycle, the bit ends up set.
- R11: Window offsets +4..+7 of a slice are the pointer, least significant byte first, and each byte can be written on its own. Pointer bits 1:0 always read 0, and the aligned pointer is driven on `ch_desc_ptr`.
- R12: Channel i's slice starts at offset i*8, and a write to one channel leaves the other channel unchanged.
- R13: Reading a register any number of times returns the same value and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 4 | Byte offset within the window |
| io_size | input | 3 | Access width in bytes (1, 2 or 4) |
| io_wdata | input | 8 | Write byte |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 32 | Read data, valid in the strobe cycle |
| hw_err_set | input | 2 | Per-channel error pulse |
| hw_irq_set | input | 2 | Per-channel interrupt pulse |
| hw_xfer_done | input | 2 | Per-channel end-of-transfer pulse from the engine |
| ch_run | output | 2 | Per-channel run bit |
| ch_dir | output | 2 | Per-channel direction bit |
| ch_active | output | 2 | Per-channel active flag |
| ch_desc_ptr | output | 64 | Per-channel aligned descriptor pointer, channel 0 in the low 32 bits |

## Verification
The status byte is written with all ones, all zeros and single-bit patterns. These separate the load-from-data bits (6:5), the clear-on-one bits (2:1), the protected active bit and the bits that always read zero. The pointer is written with a different byte in each lane, in both channels, which exposes swapped lanes, missing alignment masking and leakage between channels. Wide accesses with sizes 2 and 4 are tried on locations that hold non-zero values, so a wide write that leaks through or a mask of the wrong width shows up. Same-cycle pulse-and-clear and engine-done cases settle the priority rules.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
   localparam int BYTE_W    = 8;
   localparam int RD_BYTES  = 4;
   localparam int RD_W      = RD_BYTES * BYTE_W;
   localparam int SLICE_B   = 8;
   localparam int PTR_W     = 32;
   localparam int PTR_LANES = PTR_W / BYTE_W;

   // status bit positions
   localparam int ST_ACT = 0;
   localparam int ST_ERR = 1;
   localparam int ST_IRQ = 2;
   localparam int ST_GP0 = 5;
   localparam int ST_GP1 = 6;
   // control bit positions
   localparam int CT_RUN = 0;
   localparam int CT_DIR = 3;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_STAT = 2'd1,
      SEL_PTR  = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

   // ones in every byte lane that a wide access covers
   function automatic logic [RD_W-1:0] wide_ones(input logic [2:0] nbytes);
      logic [RD_W-1:0] m;
      m = '0;
      for (int b = 0; b < RD_BYTES; b++) begin
         if (b < int'(nbytes)) m[b*BYTE_W +: BYTE_W] = '1;
      end
      return m;
   endfunction
endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode
   import bmdma_pkg::*;
#(
   parameter int NCH = 2,
   localparam int AW = $clog2(NCH * SLICE_B),
   localparam int CW = AW - 3
) (
   input  logic [AW-1:0]          addr,
   input  logic [2:0]             size,
   input  logic                   wr,
   output logic [CW-1:0]          chan,
   output logic                   chan_ok,
   output reg_sel_e               sel,
   output logic [1:0]             lane,
   output logic                   byte_acc,
   output logic [NCH-1:0]         ctrl_we,
   output logic [NCH-1:0]         stat_we,
   output logic [NCH*PTR_LANES-1:0] ptr_we
);
   always_comb begin
      chan     = addr[AW-1:3];
      chan_ok  = (int'(chan) < NCH);
      lane     = addr[1:0];
      byte_acc = (size == 3'd1);
      if (addr[2]) begin
         sel = SEL_PTR;
      end else begin
         unique case (addr[1:0])
            2'd0:    sel = SEL_CTRL;
            2'd2:    sel = SEL_STAT;
            default: sel = SEL_NONE;
         endcase
      end
   end

   for (genvar c = 0; c < NCH; c++) begin : g_we
      logic hit;
      assign hit        = wr && byte_acc && (int'(chan) == c);
      assign ctrl_we[c] = hit && (sel == SEL_CTRL);
      assign stat_we[c] = hit && (sel == SEL_STAT);
      for (genvar l = 0; l < PTR_LANES; l++) begin : g_lane
         assign ptr_we[c*PTR_LANES+l] = hit && (sel == SEL_PTR) && (int'(lane) == l);
      end
   end
endmodule

// File: rtl/bmdma_chan_regs.sv
module bmdma_chan_regs
   import bmdma_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 ctrl_we,
   input  logic                 stat_we,
   input  logic [PTR_LANES-1:0] ptr_we,
   input  logic [BYTE_W-1:0]    wdata,
   input  logic                 err_set,
   input  logic                 irq_set,
   input  logic                 xfer_done,
   output logic [BYTE_W-1:0]    ctrl_q,
   output logic [BYTE_W-1:0]    stat_q,
   output logic [PTR_W-1:0]     ptr_q
);
   logic          run_q, dir_q, act_q, err_q, irq_q;
   logic [1:0]    gp_q;
   logic [PTR_W-1:0] ptr_r;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         dir_q <= 1'b0;
      end else if (ctrl_we) begin
         run_q <= wdata[CT_RUN];
         dir_q <= wdata[CT_DIR];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)          act_q <= 1'b0;
      else if (ctrl_we)    act_q <= wdata[CT_RUN];
      else if (xfer_done)  act_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         err_q <= 1'b0;
         irq_q <= 1'b0;
         gp_q  <= 2'b00;
      end else begin
         err_q <= err_set | (err_q & ~(stat_we & wdata[ST_ERR]));
         irq_q <= irq_set | (irq_q & ~(stat_we & wdata[ST_IRQ]));
         if (stat_we) gp_q <= wdata[ST_GP1:ST_GP0];
      end
   end

   for (genvar l = 0; l < PTR_LANES; l++) begin : g_ptr
      always_ff @(posedge clk) begin
         if (!rst_n)         ptr_r[l*BYTE_W +: BYTE_W] <= '0;
         else if (ptr_we[l]) ptr_r[l*BYTE_W +: BYTE_W] <= wdata;
      end
   end

   always_comb begin
      ctrl_q          = '0;
      ctrl_q[CT_RUN]  = run_q;
      ctrl_q[CT_DIR]  = dir_q;
      stat_q          = '0;
      stat_q[ST_ACT]  = act_q;
      stat_q[ST_ERR]  = err_q;
      stat_q[ST_IRQ]  = irq_q;
      stat_q[ST_GP1:ST_GP0] = gp_q;
      ptr_q           = {ptr_r[PTR_W-1:2], 2'b00};
   end

   // R7: a status write alone leaves the active flag where it was
   a_r7_act_sw_immune: assert property (@(posedge clk) disable iff (!rst_n)
      stat_we && !ctrl_we && !xfer_done |=> stat_q[ST_ACT] == $past(stat_q[ST_ACT]));
   // R8: starting a channel raises run and active
   a_r8_start: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we && wdata[CT_RUN] |=> stat_q[ST_ACT] && ctrl_q[CT_RUN]);
   // R9: engine-done clears active unless software writes control
   a_r9_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_done && !ctrl_we |=> !stat_q[ST_ACT]);
   // R10: a hardware pulse always leaves its flag set
   a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      err_set |=> stat_q[ST_ERR]);
   // R6: write-one clears the error flag when no pulse arrives
   a_r6_w1c: assert property (@(posedge clk) disable iff (!rst_n)
      stat_we && wdata[ST_ERR] && !err_set |=> !stat_q[ST_ERR]);
endmodule

// File: rtl/bmdma_regblock.sv
module bmdma_regblock
   import bmdma_pkg::*;
#(
   parameter int NCH = 2,
   localparam int AW = $clog2(NCH * SLICE_B)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [AW-1:0]        io_addr,
   input  logic [2:0]           io_size,
   input  logic [BYTE_W-1:0]    io_wdata,
   input  logic                 io_wr,
   input  logic                 io_rd,
   output logic [RD_W-1:0]      io_rdata,
   input  logic [NCH-1:0]       hw_err_set,
   input  logic [NCH-1:0]       hw_irq_set,
   input  logic [NCH-1:0]       hw_xfer_done,
   output logic [NCH-1:0]       ch_run,
   output logic [NCH-1:0]       ch_dir,
   output logic [NCH-1:0]       ch_active,
   output logic [NCH*PTR_W-1:0] ch_desc_ptr
);
   localparam int CW = AW - 3;

   if (NCH < 2) begin : g_bad_nch
      $error("bmdma_regblock: NCH must be at least 2");
   end

   logic [CW-1:0]            chan;
   logic                     chan_ok, byte_acc;
   reg_sel_e                 sel;
   logic [1:0]               lane;
   logic [NCH-1:0]           ctrl_we, stat_we;
   logic [NCH*PTR_LANES-1:0] ptr_we;
   logic [BYTE_W-1:0]        ctrl_q [NCH];
   logic [BYTE_W-1:0]        stat_q [NCH];
   logic [PTR_W-1:0]         ptr_q  [NCH];

   bmdma_decode #(.NCH(NCH)) i_decode (
      .addr(io_addr), .size(io_size), .wr(io_wr),
      .chan(chan), .chan_ok(chan_ok), .sel(sel), .lane(lane),
      .byte_acc(byte_acc), .ctrl_we(ctrl_we), .stat_we(stat_we), .ptr_we(ptr_we)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      bmdma_chan_regs i_chan (
         .clk(clk), .rst_n(rst_n),
         .ctrl_we(ctrl_we[c]), .stat_we(stat_we[c]),
         .ptr_we(ptr_we[c*PTR_LANES +: PTR_LANES]),
         .wdata(io_wdata),
         .err_set(hw_err_set[c]), .irq_set(hw_irq_set[c]), .xfer_done(hw_xfer_done[c]),
         .ctrl_q(ctrl_q[c]), .stat_q(stat_q[c]), .ptr_q(ptr_q[c])
      );
      assign ch_run[c]                    = ctrl_q[c][CT_RUN];
      assign ch_dir[c]                    = ctrl_q[c][CT_DIR];
      assign ch_active[c]                 = stat_q[c][ST_ACT];
      assign ch_desc_ptr[c*PTR_W +: PTR_W] = ptr_q[c];
   end

   always_comb begin
      io_rdata = '0;
      if (io_rd) begin
         if (!byte_acc) begin
            io_rdata = wide_ones(io_size);
         end else if (!chan_ok) begin
            io_rdata[BYTE_W-1:0] = '1;
         end else begin
            unique case (sel)
               SEL_CTRL: io_rdata[BYTE_W-1:0] = ctrl_q[chan];
               SEL_STAT: io_rdata[BYTE_W-1:0] = stat_q[chan];
               SEL_PTR:  io_rdata[BYTE_W-1:0] = ptr_q[chan][lane*BYTE_W +: BYTE_W];
               default:  io_rdata[BYTE_W-1:0] = '1;
            endcase
         end
      end
   end

   // R2: a wide write reaches no register
   a_r2_wide_wr_blocked: assert property (@(posedge clk) disable iff (!rst_n)
      io_wr && io_size != 3'd1 |-> ctrl_we == '0 && stat_we == '0 && ptr_we == '0);
   // R12: at most one channel is written per access
   a_r12_one_chan: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(ctrl_we | stat_we));
   // R13: status is unchanged across a pure read with no other activity
   a_r13_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      io_rd && !io_wr && hw_err_set == '0 && hw_irq_set == '0 && hw_xfer_done == '0
      |=> ch_active == $past(ch_active) && ch_run == $past(ch_run));
endmodule

// File: tb/test_bmdma_regblock.sv
module test_bmdma_regblock;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  io_addr = '0;
   logic [2:0]  io_size = 3'd1;
   logic [7:0]  io_wdata = '0;
   logic        io_wr = 1'b0, io_rd = 1'b0;
   logic [31:0] io_rdata;
   logic [1:0]  hw_err_set = '0, hw_irq_set = '0, hw_xfer_done = '0;
   logic [1:0]  ch_run, ch_dir, ch_active;
   logic [63:0] ch_desc_ptr;

   int checks = 0, errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   bmdma_regblock i_bmdma_regblock (
      .clk, .rst_n, .io_addr, .io_size, .io_wdata, .io_wr, .io_rd, .io_rdata,
      .hw_err_set, .hw_irq_set, .hw_xfer_done, .ch_run, .ch_dir, .ch_active, .ch_desc_ptr
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic [2:0] sz = 3'd1);
      @(negedge clk);
      io_addr = a; io_wdata = d; io_size = sz; io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0; io_size = 3'd1;
   endtask

   task automatic rd(input logic [3:0] a, output logic [31:0] d, input logic [2:0] sz = 3'd1);
      @(negedge clk);
      io_addr = a; io_size = sz; io_rd = 1'b1;
      #1 d = io_rdata;
      @(negedge clk);
      io_rd = 1'b0; io_size = 3'd1;
   endtask

   task automatic rd_chk(input string req, input logic [3:0] a, input logic [31:0] exp,
                         input logic [2:0] sz = 3'd1);
      logic [31:0] d;
      rd(a, d, sz);
      check(req, d, exp);
   endtask

   task automatic pulse(input logic [1:0] e, input logic [1:0] i, input logic [1:0] x);
      @(negedge clk);
      hw_err_set = e; hw_irq_set = i; hw_xfer_done = x;
      @(negedge clk);
      hw_err_set = '0; hw_irq_set = '0; hw_xfer_done = '0;
   endtask

   task automatic t_reset;
      rd_chk("R1 ctrl0", 4'd0, 32'h0);
      rd_chk("R1 stat0", 4'd2, 32'h0);
      rd_chk("R1 stat1", 4'd10, 32'h0);
      rd_chk("R1 ptr1 b3", 4'd15, 32'h0);
      check("R1 outputs", {ch_run, ch_dir, ch_active}, 64'h0);
   endtask

   task automatic t_ctrl;
      wr(4'd0, 8'hFF);
      rd_chk("R8 ctrl readback", 4'd0, 32'h09);
      rd_chk("R8 active set", 4'd2, 32'h01);
      check("R8 run/dir out", {ch_run, ch_dir}, 64'b0101);
      wr(4'd0, 8'h00);
      rd_chk("R8 active cleared", 4'd2, 32'h00);
      check("R8 run off", ch_run, 64'h0);
   endtask

   task automatic t_stat_bits;
      wr(4'd2, 8'hFF);
      rd_chk("R5 gp bits loaded", 4'd2, 32'h60);
      wr(4'd2, 8'h00);
      rd_chk("R5 gp bits cleared", 4'd2, 32'h00);
   endtask

   task automatic t_w1c;
      pulse(2'b01, 2'b01, 2'b00);
      rd_chk("R10 err+irq set", 4'd2, 32'h06);
      wr(4'd2, 8'h02);
      rd_chk("R6 err cleared only", 4'd2, 32'h04);
      wr(4'd2, 8'h04);
      rd_chk("R6 irq cleared", 4'd2, 32'h00);
   endtask

   task automatic t_active;
      wr(4'd0, 8'h01);
      wr(4'd2, 8'h00);
      rd_chk("R7 zero write keeps active", 4'd2, 32'h01);
      wr(4'd2, 8'hFF);
      rd_chk("R7 ones write keeps active", 4'd2, 32'h61);
      pulse(2'b00, 2'b00, 2'b01);
      rd_chk("R9 done clears active", 4'd2, 32'h60);
      check("R9 run unchanged", ch_run, 64'h1);
      @(negedge clk);
      io_addr = 4'd0; io_wdata = 8'h01; io_wr = 1'b1; hw_xfer_done = 2'b01;
      @(negedge clk);
      io_wr = 1'b0; hw_xfer_done = '0;
      rd_chk("R9 ctrl write wins", 4'd2, 32'h61);
      wr(4'd0, 8'h00);
      wr(4'd2, 8'h00);
   endtask

   task automatic t_set_wins;
      @(negedge clk);
      io_addr = 4'd10; io_wdata = 8'h06; io_wr = 1'b1; hw_err_set = 2'b10; hw_irq_set = 2'b10;
      @(negedge clk);
      io_wr = 1'b0; hw_err_set = '0; hw_irq_set = '0;
      rd_chk("R10 set beats clear ch1", 4'd10, 32'h06);
      rd_chk("R12 ch0 untouched", 4'd2, 32'h00);
      wr(4'd10, 8'h06);
      rd_chk("R6 ch1 cleared", 4'd10, 32'h00);
   endtask

   task automatic t_ptr;
      wr(4'd12, 8'hA7); wr(4'd13, 8'hB6); wr(4'd14, 8'hC5); wr(4'd15, 8'hD4);
      rd_chk("R11 byte0 aligned", 4'd12, 32'hA4);
      rd_chk("R11 byte2", 4'd14, 32'hC5);
      check("R11 export ch1", ch_desc_ptr[63:32], 64'hD4C5B6A4);
      check("R12 ch0 ptr zero", ch_desc_ptr[31:0], 64'h0);
      wr(4'd5, 8'h3C);
      check("R12 ch0 byte1", ch_desc_ptr[31:0], 64'h00003C00);
      check("R12 ch1 intact", ch_desc_ptr[63:32], 64'hD4C5B6A4);
   endtask

   task automatic t_wide;
      wr(4'd0, 8'h09, 3'd2);
      check("R2 wide ctrl write", {ch_run, ch_dir}, 64'h0);
      wr(4'd12, 8'h00, 3'd4);
      check("R2 wide ptr write", ch_desc_ptr[63:32], 64'hD4C5B6A4);
      rd_chk("R3 size2", 4'd12, 32'h0000FFFF, 3'd2);
      rd_chk("R3 size4", 4'd0, 32'hFFFFFFFF, 3'd4);
   endtask

   task automatic t_unused;
      rd_chk("R4 off1", 4'd1, 32'hFF);
      rd_chk("R4 off3", 4'd3, 32'hFF);
      rd_chk("R4 off9", 4'd9, 32'hFF);
      rd_chk("R4 off11", 4'd11, 32'hFF);
   endtask

   task automatic t_read_quiet;
      logic [31:0] a, b;
      pulse(2'b10, 2'b00, 2'b00);
      rd(4'd10, a);
      rd(4'd10, b);
      check("R13 first read", a, 32'h02);
      check("R13 repeat read", b, a);
      wr(4'd10, 8'h02);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_ctrl();
      t_stat_bits();
      t_w1c();
      t_active();
      t_set_wins();
      t_ptr();
      t_wide();
      t_unused();
      t_read_quiet();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule